// File: doc/BRIEF.md
# Vectored Interrupt Priority Manager

The block sits between 96 interrupt request lines and a CPU. Each of 96 priority channels reads one request line, and software picks that line through a table of 7-bit request numbers. The channel number is the priority: channel 0 wins over every other channel. Each channel has an enable bit and a type bit. The type bit sends the channel either to the fast interrupt output (FIQ) or to the normal interrupt output (IRQ). Channels 0 and 1 are hard-wired as enabled, non-maskable FIQ sources.

Software programs the table, the enables and the types over a simple synchronous word bus. It finds the IRQ to service by reading an index register. That register holds one plus the winning channel number, or zero when no enabled IRQ channel is pending. A pending-status view shows the raw state of each channel's mapped request, whether or not the channel is enabled.

The read path is a two-state machine. ST_IDLE moves to ST_RESP when rd_en is sampled high (transition RD_ISSUE). ST_RESP stays in ST_RESP on a back-to-back read (RD_CHAIN) and otherwise returns to ST_IDLE (RD_DONE). rvalid is high in ST_RESP.

Top module: `vim_prio_mgr`

## Requirements
- R1: After reset, channel n selects request n. Map word i (address i, 0..23) reads back as follows: channel 4i in bits 30:24, channel 4i+1 in bits 22:16, channel 4i+2 in bits 14:8, channel 4i+3 in bits 6:0, and all other bits zero. Word 0 reads 0x00010203 and word 23 reads 0x5C5D5E5F.
- R2: A write to map word i replaces all four of its entries. A channel is pending while the request its entry names is high, and an entry of 96 or more names no request. Pending words at addresses 0x24..0x26 show channels 32w..32w+31 at bit (channel & 31), and they show this whether or not a channel is enabled.
- R3: The enable words are reached through a set port at 0x18..0x1A and a clear port at 0x1C..0x1E. Word select is channel>>5 and bit select is channel&31. A one bit written to the set port enables that channel, a one bit written to the clear port disables it, and zero bits leave their channels unchanged. Both ports read back the enable mask. After reset, only channels 0 and 1 are enabled.
- R4: Channels 0 and 1 always read back as enabled and as FIQ type. Clear-port writes and type writes do not change this.
- R5: The type words at 0x20..0x22 use a bit of 1 to mean FIQ and 0 to mean IRQ, with the same bit layout as the enable words. After reset, type word 0 reads 3 and words 1 and 2 read 0.
- R6: The index register at 0x28 reads one plus the lowest-numbered channel that is pending, enabled and of IRQ type. It reads 0 when there is no such channel.
- R7: irq_o is high, in the same cycle, whenever any channel is pending, enabled and of IRQ type. fiq_o behaves in the same way for channels of FIQ type.
- R8: rdata and rvalid update one cycle after rd_en is sampled. rvalid is high only in that cycle. Addresses that are not listed above read 0.
- R9: When two channels name the same request, both become pending, and the lower-numbered channel wins the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| req_i | input | 96 | Interrupt request lines |
| irq_o | output | 1 | Normal interrupt to the CPU |
| fiq_o | output | 1 | Fast interrupt to the CPU |

## Verification
A corrupted table entry moves the pending bit to a different channel. The bench sees this on the next pending-status or index read, one cycle after the read strobe. It may also see irq_o or fiq_o stay low in the same cycle that a request rises. A stuck enable or type bit sends a request to the wrong output as soon as that request is driven, and a read of either enable port shows it one cycle later. A read state machine stuck in ST_RESP or ST_IDLE shows up as a wrong rvalid on the cycle after the strobe.

// File: rtl/vim_pkg.sv
package vim_pkg;
    localparam int NUM_CH_D = 96;
    localparam int REQ_W_D  = 7;
    localparam int DATA_W_D = 32;
    localparam int ADDR_W_D = 6;

    localparam int A_ENSET = 'h18;
    localparam int A_ENCLR = 'h1C;
    localparam int A_TYPE  = 'h20;
    localparam int A_PEND  = 'h24;
    localparam int A_INDEX = 'h28;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_e;
endpackage

// File: rtl/vim_map_table.sv
module vim_map_table #(
    parameter int NUM_CH = 96,
    parameter int REQ_W  = 7,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] pend_o,
    output logic [DATA_W-1:0] map_rd
);
    logic [REQ_W-1:0] map_q [NUM_CH];

    // Four entries per word, lowest channel in the top byte
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n)
                map_q[c] <= REQ_W'(c);
            else if (wr_en && int'(addr) == c / 4)
                map_q[c] <= wdata[(24 - 8 * (c % 4)) +: REQ_W];
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            pend_o[c] = (int'(map_q[c]) < NUM_CH) ? req_i[map_q[c]] : 1'b0;
    end

    always_comb begin
        map_rd = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (int'(addr) == c / 4)
                map_rd[(24 - 8 * (c % 4)) +: REQ_W] = map_q[c];
    end
endmodule

// File: rtl/vim_mask_regs.sv
module vim_mask_regs #(
    parameter int NUM_CH   = 96,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int SET_BASE = 'h18,
    parameter int CLR_BASE = 'h1C,
    parameter int TYP_BASE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] fiq_type_o,
    output logic [DATA_W-1:0] en_rd,
    output logic [DATA_W-1:0] type_rd
);
    localparam int WORDS = NUM_CH / DATA_W;
    localparam logic [NUM_CH-1:0] FIXED = NUM_CH'(3);

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] type_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            type_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (int'(addr) == SET_BASE + w)
                    en_q[w*DATA_W +: DATA_W] <= en_q[w*DATA_W +: DATA_W] | wdata;
                if (int'(addr) == CLR_BASE + w)
                    en_q[w*DATA_W +: DATA_W] <= en_q[w*DATA_W +: DATA_W] & ~wdata;
                if (int'(addr) == TYP_BASE + w)
                    type_q[w*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

    assign en_o       = en_q | FIXED;
    assign fiq_type_o = type_q | FIXED;

    always_comb begin
        en_rd   = '0;
        type_rd = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(addr[1:0]) == w) begin
                en_rd   = en_o[w*DATA_W +: DATA_W];
                type_rd = fiq_type_o[w*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/vim_prio_enc.sv
module vim_prio_enc #(
    parameter int NUM_CH = 96,
    parameter int IDX_W  = 7
) (
    input  logic [NUM_CH-1:0] act_i,
    output logic [IDX_W-1:0]  idx_o
);
    // Scan from the lowest priority up so channel 0 is written last
    always_comb begin
        idx_o = '0;
        for (int c = NUM_CH - 1; c >= 0; c--)
            if (act_i[c])
                idx_o = IDX_W'(c + 1);
    end
endmodule

// File: rtl/vim_prio_mgr.sv
module vim_prio_mgr
    import vim_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_D,
    parameter int REQ_W  = REQ_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic [NUM_CH-1:0] req_i,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int MAP_WORDS  = NUM_CH / 4;
    localparam int MASK_WORDS = NUM_CH / DATA_W;
    localparam int IDX_W      = $clog2(NUM_CH + 1);

    logic [NUM_CH-1:0] pend_vec, en_vec, type_vec, irq_act, fiq_act;
    logic [DATA_W-1:0] map_rd, en_rd, type_rd, pend_rd, rd_mux, rdata_q;
    logic [IDX_W-1:0]  irq_idx;
    bus_st_e           state_q, state_d;

    vim_map_table #(.NUM_CH(NUM_CH), .REQ_W(REQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .req_i(req_i), .pend_o(pend_vec), .map_rd(map_rd)
    );

    vim_mask_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .SET_BASE(A_ENSET), .CLR_BASE(A_ENCLR), .TYP_BASE(A_TYPE)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .en_o(en_vec), .fiq_type_o(type_vec), .en_rd(en_rd), .type_rd(type_rd)
    );

    assign irq_act = pend_vec & en_vec & ~type_vec;
    assign fiq_act = pend_vec & en_vec & type_vec;
    assign irq_o   = |irq_act;
    assign fiq_o   = |fiq_act;

    vim_prio_enc #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_enc (
        .act_i(irq_act), .idx_o(irq_idx)
    );

    always_comb begin
        pend_rd = '0;
        for (int w = 0; w < MASK_WORDS; w++)
            if (int'(addr[1:0]) == w)
                pend_rd = pend_vec[w*DATA_W +: DATA_W];
    end

    always_comb begin
        rd_mux = '0;
        if (int'(addr) < MAP_WORDS)
            rd_mux = map_rd;
        else if ((int'(addr) >= A_ENSET && int'(addr) < A_ENSET + MASK_WORDS) ||
                 (int'(addr) >= A_ENCLR && int'(addr) < A_ENCLR + MASK_WORDS))
            rd_mux = en_rd;
        else if (int'(addr) >= A_TYPE && int'(addr) < A_TYPE + MASK_WORDS)
            rd_mux = type_rd;
        else if (int'(addr) >= A_PEND && int'(addr) < A_PEND + MASK_WORDS)
            rd_mux = pend_rd;
        else if (int'(addr) == A_INDEX)
            rd_mux = DATA_W'(irq_idx);
    end

    // Read-response state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_en) state_d = ST_RESP;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    // Outputs
    always_comb begin
        rdata = rdata_q;
        unique case (state_q)
            ST_IDLE: rvalid = 1'b0;
            ST_RESP: rvalid = 1'b1;
        endcase
    end
endmodule

// File: rtl/vim_prio_mgr_chk.sv
module vim_prio_mgr_chk #(
    parameter int NUM_CH = 96,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rvalid,
    input logic              irq_o,
    input logic [IDX_W-1:0]  idx,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] type_vec
);
    AST_IDX_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) == irq_o);                                        // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) <= NUM_CH);                                          // R6
    AST_IDX_NOT_FIQ_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) != 1) && (int'(idx) != 2));                         // R4
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);                                             // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);                                           // R8
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_vec));                                   // R3
    AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(type_vec));                                 // R5
endmodule

bind vim_prio_mgr vim_prio_mgr_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rvalid(rvalid),
    .irq_o(irq_o), .idx(irq_idx), .en_vec(en_vec), .type_vec(type_vec)
);

// File: tb/sim_vim_prio_mgr.sv
`timescale 1ns/1ps
module sim_vim_prio_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [95:0] req_i = '0;
    logic        irq_o, fiq_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vim_prio_mgr u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .req_i(req_i),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct packed {
        logic [6:0] ra;
        logic [6:0] rb;
        logic [6:0] idx;
        logic       irq;
        logic       fiq;
    } vec_t;

    // 127 = no request; identity map, all channels enabled
    localparam vec_t VEC [8] = '{
        '{7'd127, 7'd127, 7'd0,  1'b0, 1'b0},
        '{7'd5,   7'd127, 7'd6,  1'b1, 1'b0},
        '{7'd40,  7'd5,   7'd6,  1'b1, 1'b0},
        '{7'd95,  7'd127, 7'd96, 1'b1, 1'b0},
        '{7'd0,   7'd127, 7'd0,  1'b0, 1'b1},
        '{7'd1,   7'd70,  7'd71, 1'b1, 1'b1},
        '{7'd31,  7'd32,  7'd32, 1'b1, 1'b0},
        '{7'd64,  7'd127, 7'd65, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        chk("R8 rvalid", 32'(rvalid), 32'd1);
    endtask

    task automatic drive(input logic [6:0] ra, input logic [6:0] rb);
        @(negedge clk);
        req_i = '0;
        if (ra < 96) req_i[ra] = 1'b1;
        if (rb < 96) req_i[rb] = 1'b1;
        #1;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R7 reset irq", 32'(irq_o), 32'd0);
        chk("R7 reset fiq", 32'(fiq_o), 32'd0);
        rd(6'h00, d); chk("R1 map word 0", d, 32'h00010203);
        rd(6'h17, d); chk("R1 map word 23", d, 32'h5C5D5E5F);
        rd(6'h18, d); chk("R3 reset enable word 0", d, 32'h3);
        rd(6'h19, d); chk("R3 reset enable word 1", d, 32'h0);
        rd(6'h20, d); chk("R5 reset type word 0", d, 32'h3);
        rd(6'h22, d); chk("R5 reset type word 2", d, 32'h0);
        rd(6'h28, d); chk("R6 reset index", d, 32'h0);
        @(negedge clk);
        chk("R8 rvalid drops", 32'(rvalid), 32'd0);

        for (int w = 0; w < 3; w++) wr(6'(6'h18 + w), 32'hFFFF_FFFF);
        rd(6'h1E, d); chk("R3 clear port reads mask", d, 32'hFFFF_FFFF);

        // Stimulus table
        foreach (VEC[i]) begin
            drive(VEC[i].ra, VEC[i].rb);
            chk($sformatf("R7 irq vec %0d", i), 32'(irq_o), 32'(VEC[i].irq));
            chk($sformatf("R7 fiq vec %0d", i), 32'(fiq_o), 32'(VEC[i].fiq));
            rd(6'h28, d); chk($sformatf("R6 index vec %0d", i), d, 32'(VEC[i].idx));
        end

        // Enable clear, zero bits, fixed channels
        wr(6'h1C, 32'h20);
        drive(7'd5, 7'd40);
        rd(6'h28, d); chk("R3 cleared ch5 skipped", d, 32'd41);
        rd(6'h18, d); chk("R3 mask after clear", d, 32'hFFFF_FFDF);
        wr(6'h1C, 32'h3);
        rd(6'h18, d); chk("R4 ch0/1 survive clear", d, 32'hFFFF_FFDF);
        wr(6'h18, 32'h0);
        rd(6'h1C, d); chk("R3 zero set bits no effect", d, 32'hFFFF_FFDF);
        wr(6'h18, 32'h20);

        // Type selection
        wr(6'h21, 32'h1);
        drive(7'd32, 7'd127);
        chk("R5 ch32 as fiq: fiq", 32'(fiq_o), 32'd1);
        chk("R5 ch32 as fiq: irq", 32'(irq_o), 32'd0);
        rd(6'h28, d); chk("R5 fiq channel not indexed", d, 32'd0);
        rd(6'h21, d); chk("R5 type word 1", d, 32'h1);
        wr(6'h20, 32'h0);
        rd(6'h20, d); chk("R4 ch0/1 stay fiq", d, 32'h3);
        wr(6'h21, 32'h0);

        // Remap with duplicate
        wr(6'h00, 32'h00013203);
        rd(6'h00, d); chk("R2 map word 0 readback", d, 32'h00013203);
        drive(7'd50, 7'd127);
        rd(6'h28, d); chk("R9 duplicate lower wins", d, 32'd3);
        rd(6'h24, d); chk("R2 pending word 0", d, 32'h4);
        rd(6'h25, d); chk("R9 both see request", d, 32'h0004_0000);
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h24, d); chk("R2 pending ignores enable", d, 32'h4);
        wr(6'h18, 32'hFFFF_FFFF);

        // Out-of-range entry
        wr(6'h01, 32'h7F050607);
        rd(6'h01, d); chk("R2 map word 1 readback", d, 32'h7F050607);
        @(negedge clk); req_i = '1; #1;
        rd(6'h24, d); chk("R2 entry 127 never pending", d, 32'hFFFF_FFEF);
        rd(6'h28, d); chk("R6 all pending index", d, 32'd3);

        rd(6'h3F, d); chk("R8 unmapped address", d, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule